// File: doc/BRIEF.md
# SPI Buffer DMA Channel Pair

This block moves words between an SPI data path and memory without processor help. It holds two independent channels. The receive channel empties the receive holding register into a memory buffer. The transmit channel fetches words from a memory buffer into the transmit holding register. Each channel has a pointer register, which gives the address of the next word, and a counter register, which gives the number of words still to move.

Software loads a pointer and a nonzero count through a small write-only configuration port. The SPI side raises a flag: receive-full when a word has arrived, or transmit-empty when the shifter can take a word. The channel then runs one beat on a single memory port. The beat is a write for receive and a read for transmit. After the beat the channel acknowledges the SPI side with a one-cycle pulse. Each finished beat lowers the count by one and advances the pointer by the word size in bytes.

When the count is zero the channel idles, and its end flag shows that condition directly. Loading a nonzero count clears the flag again. An interrupt line combines the end flags with per-channel enable bits.

The memory port is a valid/ready stream with back-pressure. The block raises `mem_valid` together with `mem_we`, `mem_addr` and `mem_wdata`, and holds all four unchanged until the cycle in which `mem_ready` is high. That cycle completes the beat. For a read, `mem_rdata` is sampled in that same cycle. The memory may hold `mem_ready` low for any number of cycles.

Top module: `spidma_pair`

## Requirements
- R1: After reset both counts and pointers are zero and both interrupt enables are off, so `end_rx`=1, `end_tx`=1, `irq`=0 and `mem_valid`=0.
- R2: A configuration write with `cfg_we`=1 loads a register selected by `cfg_addr`, and takes effect at that clock edge:
  - 0: receive pointer
  - 1: receive count
  - 2: transmit pointer
  - 3: transmit count
  - 4: set enable bits from `cfg_wdata[1:0]` (bit 0 receive, bit 1 transmit)
  - 5: clear the enable bits marked in `cfg_wdata[1:0]`
- R3: With `rx_full`=1 and a nonzero receive count, the block issues a memory write of `rx_data` at the receive pointer. In the cycle after the accepting beat, `rx_take` pulses high for exactly one cycle.
- R4: With `tx_empty`=1 and a nonzero transmit count, the block issues a memory read at the transmit pointer. In the cycle after the accepting beat, `tx_load` pulses high for one cycle, with `tx_data` equal to the word that was read.
- R5: Each accepted beat lowers that channel's count by 1. It also advances that channel's pointer by 2 when the data width exceeds 8 bits (the default is 16), or by 1 for 8-bit data.
- R6: Each end flag is high exactly while its count is zero. While a channel's count is zero its request flag is ignored: no memory beat and no acknowledge pulse occur.
- R7: `irq` is high when, for either channel, both that channel's end flag and its enable bit are high.
- R8: When both flags are pending and both counts are nonzero while the engine is idle, the receive beat is issued before the transmit beat.
- R9: While `mem_valid`=1 and `mem_ready`=0, the signals `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: One raised flag yields exactly one beat. No second beat starts for a channel until its flag is raised again after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| rx_full | input | 1 | Receive holding register full |
| rx_data | input | 16 | Receive holding register contents |
| rx_take | output | 1 | Receive word consumed (clears full) |
| tx_empty | input | 1 | Transmit holding register empty |
| tx_load | output | 1 | Load strobe for transmit holding register |
| tx_data | output | 16 | Word for transmit holding register |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts beat this cycle |
| mem_we | output | 1 | Beat is a write (1) or read (0) |
| mem_addr | output | 16 | Beat byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the accepting cycle |
| end_rx | output | 1 | Receive count is zero |
| end_tx | output | 1 | Transmit count is zero |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the SPI side holds `rx_full` high with `rx_data` steady until it sees `rx_take`, and then drops the flag before the next cycle. They assume the same of `tx_empty` until `tx_load`. The bench's SPI model reacts to each acknowledge on the same half-cycle. It only raises a flag again once the flag has been dropped, and software writes are issued only while no beat is pending. Memory stalls follow a fixed pattern, and read data is a fixed function of the address, so each expected transmit word is known before the beat runs.

// File: rtl/spidma_pkg.sv
package spidma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } eng_state_t;

  localparam int CH_RX = 0;
  localparam int CH_TX = 1;
  localparam int NUM_CH = 2;

  localparam logic [2:0] CFG_RX_PTR = 3'd0;
  localparam logic [2:0] CFG_RX_CNT = 3'd1;
  localparam logic [2:0] CFG_TX_PTR = 3'd2;
  localparam logic [2:0] CFG_TX_CNT = 3'd3;
  localparam logic [2:0] CFG_EN_SET = 3'd4;
  localparam logic [2:0] CFG_EN_CLR = 3'd5;
endpackage

// File: rtl/spidma_chan.sv
module spidma_chan #(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ptr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ptr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          beat_done,
  output logic [AW-1:0] ptr,
  output logic          cnt_zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ld_ptr) begin
      ptr <= ptr_in;
    end else if (beat_done) begin
      ptr <= ptr + AW'(STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_cnt) begin
      cnt <= cnt_in;
    end else if (beat_done && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign cnt_zero = (cnt == '0);

  // R6: a zero count stays zero until software reloads it
  assert_zero_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !ld_cnt) |=> cnt_zero);

  // R5: a finished beat advances the pointer by one word
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !ld_ptr) |=> (ptr == $past(ptr) + AW'(STEP)));
endmodule

// File: rtl/spidma_engine.sv
module spidma_engine
  import spidma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_full,
  input  logic [DW-1:0]     rx_data,
  input  logic              tx_empty,
  input  logic [AW-1:0]     rx_ptr,
  input  logic [AW-1:0]     tx_ptr,
  input  logic              rx_zero,
  input  logic              tx_zero,
  output logic [NUM_CH-1:0] beat_done,
  output logic              rx_take,
  output logic              tx_load,
  output logic [DW-1:0]     tx_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  eng_state_t    state;
  logic          sel_tx;
  logic          rx_go;
  logic          tx_go;
  logic          accept;

  assign rx_go  = rx_full && !rx_zero;
  assign tx_go  = tx_empty && !tx_zero;
  assign accept = (state == ST_BUSY) && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_tx    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_data   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rx_go) begin
            state     <= ST_BUSY;
            sel_tx    <= 1'b0;
            mem_we    <= 1'b1;
            mem_addr  <= rx_ptr;
            mem_wdata <= rx_data;
          end else if (tx_go) begin
            state     <= ST_BUSY;
            sel_tx    <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= tx_ptr;
          end
        end
        ST_BUSY: begin
          if (mem_ready) begin
            state <= ST_DONE;
            if (sel_tx) tx_data <= mem_rdata;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = (state == ST_BUSY);
  assign beat_done[CH_RX] = accept && !sel_tx;
  assign beat_done[CH_TX] = accept && sel_tx;
  assign rx_take = (state == ST_DONE) && !sel_tx;
  assign tx_load = (state == ST_DONE) && sel_tx;

  // R9: a stalled beat keeps its request fields steady
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata)));

  // R10: acknowledge pulses last one cycle
  assert_take_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> !rx_take);
  assert_load_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  // R3: receive acknowledge follows an accepted write beat
  assert_take_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> rx_take);

  // R4: transmit load follows an accepted read beat
  assert_load_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> tx_load);
endmodule

// File: rtl/spidma_irq.sv
module spidma_irq
  import spidma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [NUM_CH-1:0] en_bits,
  input  logic [NUM_CH-1:0] end_flags,
  output logic              irq
);
  logic [NUM_CH-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (en_set) begin
      mask <= mask | en_bits;
    end else if (en_clr) begin
      mask <= mask & ~en_bits;
    end
  end

  assign irq = |(mask & end_flags);

  // R7: with every enable cleared the line stays low
  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && en_bits == '1) |=> !irq);
endmodule

// File: rtl/spidma_pair.sv
module spidma_pair
  import spidma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [2:0]                       cfg_addr,
  input  logic [((AW > CW) ? AW : CW)-1:0] cfg_wdata,
  input  logic                             rx_full,
  input  logic [DW-1:0]                    rx_data,
  output logic                             rx_take,
  input  logic                             tx_empty,
  output logic                             tx_load,
  output logic [DW-1:0]                    tx_data,
  output logic                             mem_valid,
  input  logic                             mem_ready,
  output logic                             mem_we,
  output logic [AW-1:0]                    mem_addr,
  output logic [DW-1:0]                    mem_wdata,
  input  logic [DW-1:0]                    mem_rdata,
  output logic                             end_rx,
  output logic                             end_tx,
  output logic                             irq
);
  localparam int STEP = (DW > 8) ? 2 : 1;

  logic [AW-1:0]     ptr   [NUM_CH];
  logic [NUM_CH-1:0] zero;
  logic [NUM_CH-1:0] done;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam logic [2:0] PTR_SEL = (i == CH_RX) ? CFG_RX_PTR : CFG_TX_PTR;
    localparam logic [2:0] CNT_SEL = (i == CH_RX) ? CFG_RX_CNT : CFG_TX_CNT;
    spidma_chan #(.AW(AW), .CW(CW), .STEP(STEP)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_ptr    (cfg_we && cfg_addr == PTR_SEL),
      .ld_cnt    (cfg_we && cfg_addr == CNT_SEL),
      .ptr_in    (cfg_wdata[AW-1:0]),
      .cnt_in    (cfg_wdata[CW-1:0]),
      .beat_done (done[i]),
      .ptr       (ptr[i]),
      .cnt_zero  (zero[i])
    );
  end

  spidma_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_full   (rx_full),
    .rx_data   (rx_data),
    .tx_empty  (tx_empty),
    .rx_ptr    (ptr[CH_RX]),
    .tx_ptr    (ptr[CH_TX]),
    .rx_zero   (zero[CH_RX]),
    .tx_zero   (zero[CH_TX]),
    .beat_done (done),
    .rx_take   (rx_take),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  spidma_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set    (cfg_we && cfg_addr == CFG_EN_SET),
    .en_clr    (cfg_we && cfg_addr == CFG_EN_CLR),
    .en_bits   (cfg_wdata[NUM_CH-1:0]),
    .end_flags (zero),
    .irq       (irq)
  );

  assign end_rx = zero[CH_RX];
  assign end_tx = zero[CH_TX];

  // R8: the two acknowledges never coincide
  assert_one_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_take && tx_load));

  // R6: an idle channel with zero count starts no beat
  assert_no_beat_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && end_rx && end_tx && !cfg_we) |=> !mem_valid);
endmodule

// File: tb/spidma_pair_bench.sv
module spidma_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        rx_full = 1'b0;
  logic [15:0] rx_data = '0;
  logic        rx_take;
  logic        tx_empty = 1'b0;
  logic        tx_load;
  logic [15:0] tx_data;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        end_rx;
  logic        end_tx;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit stall_on = 1'b0;
  bit held = 1'b0;
  logic [32:0] held_beat;

  logic [32:0] exp_beats[$];  // {we, addr, data}
  logic [15:0] exp_tx[$];

  always #4 clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'hA5C3;

  spidma_pair u_spidma_pair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_full(rx_full), .rx_data(rx_data),
    .rx_take(rx_take), .tx_empty(tx_empty), .tx_load(tx_load),
    .tx_data(tx_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .end_rx(end_rx), .end_tx(end_tx), .irq(irq)
  );

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_ready = stall_on ? (cyc[1:0] == 2'b11) : 1'b1;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  // monitor: memory beats and acknowledges
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_valid) begin
      if (held) check("R9 stall hold", {mem_we, mem_addr, mem_wdata}, held_beat);
      held = 1'b0;
      if (mem_ready) begin
        if (exp_beats.size() == 0) begin
          check("R10 unexpected beat", {mem_we, mem_addr, mem_wdata}, 33'h0);
        end else begin
          logic [32:0] e;
          e = exp_beats.pop_front();
          check("R3/R4/R5/R8 beat", mem_we ? {mem_we, mem_addr, mem_wdata}
                : {mem_we, mem_addr, 16'h0}, e);
        end
      end else begin
        held = 1'b1;
        held_beat = {mem_we, mem_addr, mem_wdata};
      end
    end
    if (rx_take) rx_full = 1'b0;
    if (tx_load) begin
      if (exp_tx.size() == 0) begin
        check("R10 unexpected tx_load", {17'h0, tx_data}, 33'h0);
      end else begin
        logic [15:0] t;
        t = exp_tx.pop_front();
        check("R4 tx_data", {17'h0, tx_data}, {17'h0, t});
      end
      tx_empty = 1'b0;
    end
  end

  task automatic cfg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_rx(logic [15:0] addr, logic [15:0] d);
    while (rx_full) @(negedge clk);
    exp_beats.push_back({1'b1, addr, d});
    rx_data = d;
    rx_full = 1'b1;
  endtask

  task automatic send_tx(logic [15:0] addr);
    while (tx_empty) @(negedge clk);
    exp_beats.push_back({1'b0, addr, 16'h0});
    exp_tx.push_back(addr ^ 16'hA5C3);
    tx_empty = 1'b1;
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    while ((exp_beats.size() != 0 || exp_tx.size() != 0 || rx_full
            || tx_empty || mem_valid) && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check("R10 queue drained", 33'(exp_beats.size() + exp_tx.size()), 33'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1
    check("R1 reset flags", {29'h0, end_rx, end_tx, irq, mem_valid}, 33'b1100);

    // R2 R3 R5 R6: three receive words with memory stalls
    cfg(3'd0, 16'h0100);
    cfg(3'd1, 16'd3);
    #2 check("R2 R6 count load clears end_rx", {32'h0, end_rx}, 33'h0);
    stall_on = 1'b1;
    for (int k = 0; k < 3; k++) send_rx(16'h0100 + 16'(2 * k), 16'h1230 + 16'(k));
    drain();
    check("R6 end_rx after count exhausted", {32'h0, end_rx}, 33'h1);

    // R6: request ignored while count is zero
    rx_data = 16'hBEEF;
    rx_full = 1'b1;
    repeat (15) @(negedge clk);
    #2 check("R6 flag ignored at zero", {31'h0, rx_full, rx_take}, 33'b10);
    exp_beats.push_back({1'b1, 16'h0106, 16'hBEEF});
    cfg(3'd1, 16'd1);
    drain();
    check("R6 end_rx set again", {32'h0, end_rx}, 33'h1);

    // R4: transmit reads
    stall_on = 1'b0;
    cfg(3'd2, 16'h0200);
    cfg(3'd3, 16'd2);
    send_tx(16'h0200);
    send_tx(16'h0202);
    drain();
    check("R4 R6 end_tx after reads", {32'h0, end_tx}, 33'h1);

    // R8: simultaneous requests, receive goes first
    cfg(3'd0, 16'h0300);
    cfg(3'd1, 16'd1);
    cfg(3'd2, 16'h0400);
    cfg(3'd3, 16'd1);
    exp_beats.push_back({1'b1, 16'h0300, 16'h5A5A});
    exp_beats.push_back({1'b0, 16'h0400, 16'h0});
    exp_tx.push_back(16'h0400 ^ 16'hA5C3);
    rx_data = 16'h5A5A;
    rx_full = 1'b1;
    tx_empty = 1'b1;
    drain();

    // R10: count of two, one flag gives one beat
    cfg(3'd0, 16'h0500);
    cfg(3'd1, 16'd2);
    send_rx(16'h0500, 16'h7777);
    drain();
    check("R10 one beat per flag", {32'h0, end_rx}, 33'h0);
    send_rx(16'h0502, 16'h8888);
    drain();

    // R7: interrupt enables
    cfg(3'd4, 16'h0001);
    #2 check("R7 irq rx enabled", {32'h0, irq}, 33'h1);
    cfg(3'd5, 16'h0001);
    #2 check("R7 irq rx disabled", {32'h0, irq}, 33'h0);
    cfg(3'd4, 16'h0002);
    #2 check("R7 irq tx enabled", {32'h0, irq}, 33'h1);
    cfg(3'd3, 16'd5);
    #2 check("R7 irq drops when end_tx clears", {32'h0, irq}, 33'h0);
    cfg(3'd5, 16'h0003);

    summary();
  end
endmodule